// File: doc/BRIEF.md
# Hitless Reference Switch Phase Corrector

This block sits between the phase measurement of a clock synchronizer and its loop filter. It holds a stored phase offset and passes on the measured phase of the active reference minus that offset. Because the offset is taken from the current measurement whenever the selected reference changes, the loop sees no step, and the output clock does not jump when the reference changes. The block also handles the loop coming back out of holdover. A mode input chooses between two behaviours. In one, the offset is kept, so the output drifts back to its phase from before holdover. In the other, the offset is recaptured, so the output stays where it is.

An active-low clear input, which may change at any time, zeroes the offset. The loop then pulls the output into alignment with the selected reference. Keeping clear low keeps the output aligned to whichever reference is chosen. The difference is taken as a signed modular value, so any correction runs along the shorter way around the phase circle. A slope limit caps the size of the error handed on in each clock.

Top module: `hitless_phase_corrector`

## Requirements
- R1: While `rst_n` is low, `offset_out` is 0. After reset it stays 0 until a capture or clear changes it.
- R2: With clear inactive, a cycle with `ref_switch` high loads `meas_phase` into `offset_out` at the next rising edge. This happens whatever the level of `hitless_hold`.
- R3: With clear inactive and `hitless_hold` high, a cycle with `hold_exit` high loads `meas_phase` into `offset_out` at the next rising edge.
- R4: With clear inactive and `hitless_hold` low, `hold_exit` has no effect on `offset_out`.
- R5: `clr_n` is synchronized through two flops. It counts as active only when the synchronized value has been low for two consecutive clocks. A low level that is held across two sampling edges zeroes `offset_out` at the third rising edge after the first of those edges. A low level seen at one sampling edge only is ignored.
- R6: While the clear is active, it takes priority over `ref_switch` and `hold_exit`. If `clr_n` is held low, `offset_out` stays 0.
- R7: Before limiting, the error is the 16-bit two's-complement wrap of `meas_phase - offset_out`. Example: measured 0x0010 with offset 0xFFF0 gives +0x0020. Measured 0xFFF0 with offset 0x0010 gives -0x0020 (0xFFE0).
- R8: `err_out` is the R7 error clamped to the range -`slope_lim` to +`slope_lim`, with `slope_lim` unsigned. An error of -32768 with limit 0x7FFF comes out as 0x8001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| meas_phase | input | 16 | Measured phase of the active reference, unsigned modular |
| ref_switch | input | 1 | Strobe: the selected reference changed this cycle |
| hold_exit | input | 1 | Strobe: the loop is leaving holdover or freerun this cycle |
| hitless_hold | input | 1 | 1 = recapture the offset on holdover exit, 0 = keep it |
| clr_n | input | 1 | Asynchronous active-low offset clear |
| slope_lim | input | 15 | Largest error magnitude passed on per clock |
| err_out | output | 16 | Slew-limited signed phase error for the loop filter |
| offset_out | output | 16 | Currently stored phase offset |

## Verification
Two functions can act in the same cycle: an offset capture from `ref_switch` or `hold_exit`, and the confirmed clear. The bench holds `clr_n` low until the clear is active and then pulses both strobes with a nonzero measured phase. It expects `offset_out` to stay 0 and `err_out` to equal the clamped raw phase. It also checks that a clear pulse seen at only one edge, arriving around an earlier capture, leaves the captured offset unchanged.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  parameter int unsigned HPC_PHASE_W = 16;

  typedef enum logic [1:0] {
    UPD_KEEP    = 2'd0,
    UPD_CAPTURE = 2'd1,
    UPD_ZERO    = 2'd2
  } upd_e;
endpackage

// File: rtl/hpc_clr_sync.sv
module hpc_clr_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONFIRM     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n_in,
  output logic clr_hit
);
  localparam int unsigned DEPTH = SYNC_STAGES + CONFIRM - 1;
  localparam int unsigned LOW   = SYNC_STAGES - 1;

  logic [DEPTH-1:0] stage_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = clr_n_in;
    end else begin : g_next
      assign d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b1;
      else        stage_q[i] <= d;
    end
  end

  // active only after CONFIRM consecutive low synchronized samples
  assign clr_hit = ~|stage_q[DEPTH-1:LOW];
endmodule

// File: rtl/hpc_offset_store.sv
module hpc_offset_store
  import hpc_pkg::*;
#(
  parameter int unsigned W = HPC_PHASE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_hit,
  input  logic         ref_switch,
  input  logic         hold_exit,
  input  logic         hitless_hold,
  input  logic [W-1:0] meas_phase,
  output logic [W-1:0] offset_q
);
  upd_e         upd;
  logic [W-1:0] offset_d;
  logic         offset_en;

  always_comb begin
    if (clr_hit)                         upd = UPD_ZERO;
    else if (ref_switch)                 upd = UPD_CAPTURE;
    else if (hold_exit && hitless_hold)  upd = UPD_CAPTURE;
    else                                 upd = UPD_KEEP;
  end

  always_comb begin
    offset_en = 1'b1;
    offset_d  = offset_q;
    unique case (upd)
      UPD_ZERO:    offset_d = '0;
      UPD_CAPTURE: offset_d = meas_phase;
      default:     offset_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         offset_q <= '0;
    else if (offset_en) offset_q <= offset_d;
  end
endmodule

// File: rtl/hpc_slew_clamp.sv
module hpc_slew_clamp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] raw,
  input  logic [W-2:0] lim,
  output logic [W-1:0] limited
);
  logic signed [W-1:0] raw_s;
  logic signed [W-1:0] pos_s;
  logic signed [W-1:0] neg_s;

  assign raw_s = $signed(raw);
  assign pos_s = $signed({1'b0, lim});
  assign neg_s = -pos_s;

  always_comb begin
    if (raw_s > pos_s)      limited = pos_s;
    else if (raw_s < neg_s) limited = neg_s;
    else                    limited = raw;
  end
endmodule

// File: rtl/hitless_phase_corrector.sv
module hitless_phase_corrector
  import hpc_pkg::*;
#(
  parameter int unsigned PHASE_W     = HPC_PHASE_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONFIRM     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] meas_phase,
  input  logic               ref_switch,
  input  logic               hold_exit,
  input  logic               hitless_hold,
  input  logic               clr_n,
  input  logic [PHASE_W-2:0] slope_lim,
  output logic [PHASE_W-1:0] err_out,
  output logic [PHASE_W-1:0] offset_out
);
  logic               clr_hit;
  logic [PHASE_W-1:0] raw_err;

  hpc_clr_sync #(.SYNC_STAGES(SYNC_STAGES), .CONFIRM(CONFIRM)) u_clr_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n_in (clr_n),
    .clr_hit  (clr_hit)
  );

  hpc_offset_store #(.W(PHASE_W)) u_offset (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_hit      (clr_hit),
    .ref_switch   (ref_switch),
    .hold_exit    (hold_exit),
    .hitless_hold (hitless_hold),
    .meas_phase   (meas_phase),
    .offset_q     (offset_out)
  );

  // modular subtraction: the signed reading is the shorter way round
  assign raw_err = meas_phase - offset_out;

  hpc_slew_clamp #(.W(PHASE_W)) u_clamp (
    .raw     (raw_err),
    .lim     (slope_lim),
    .limited (err_out)
  );
endmodule

// File: rtl/hitless_phase_corrector_chk.sv
module hitless_phase_corrector_chk #(
  parameter int unsigned PHASE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] meas_phase,
  input logic               ref_switch,
  input logic               hold_exit,
  input logic               hitless_hold,
  input logic               clr_hit,
  input logic [PHASE_W-2:0] slope_lim,
  input logic [PHASE_W-1:0] err_out,
  input logic [PHASE_W-1:0] offset_out
);
  a_r2_switch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_switch && !clr_hit) |=> (offset_out == $past(meas_phase)));

  a_r3_exit_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_exit && hitless_hold && !clr_hit) |=> (offset_out == $past(meas_phase)));

  a_r4_exit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_exit && !hitless_hold && !ref_switch && !clr_hit) |=> $stable(offset_out));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (offset_out == '0));

  a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(err_out) <= $signed({1'b0, slope_lim})) &&
    ($signed(err_out) >= -$signed({1'b0, slope_lim})));
endmodule

bind hitless_phase_corrector hitless_phase_corrector_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .meas_phase   (meas_phase),
  .ref_switch   (ref_switch),
  .hold_exit    (hold_exit),
  .hitless_hold (hitless_hold),
  .clr_hit      (clr_hit),
  .slope_lim    (slope_lim),
  .err_out      (err_out),
  .offset_out   (offset_out)
);

// File: tb/hitless_phase_corrector_tb.sv
module hitless_phase_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] meas_phase;
  logic        ref_switch;
  logic        hold_exit;
  logic        hitless_hold;
  logic        clr_n;
  logic [14:0] slope_lim;
  logic [15:0] err_out;
  logic [15:0] offset_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hitless_phase_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .meas_phase(meas_phase), .ref_switch(ref_switch),
    .hold_exit(hold_exit), .hitless_hold(hitless_hold), .clr_n(clr_n),
    .slope_lim(slope_lim), .err_out(err_out), .offset_out(offset_out)
  );

  // {offset to load, measured phase, limit, expected err_out}
  localparam logic [63:0] VEC [7] = '{
    {16'hFFF0, 16'h0010, 16'h7FFF, 16'h0020},   // R7 wrap forward
    {16'h0010, 16'hFFF0, 16'h7FFF, 16'hFFE0},   // R7 wrap backward
    {16'h1000, 16'h1100, 16'h0040, 16'h0040},   // R8 positive clamp
    {16'h1000, 16'h0F00, 16'h0040, 16'hFFC0},   // R8 negative clamp
    {16'h0000, 16'h8000, 16'h7FFF, 16'h8001},   // R8 half-circle case
    {16'h4000, 16'h4000, 16'h0000, 16'h0000},   // R8 zero limit
    {16'h0000, 16'h7FFF, 16'h7FFF, 16'h7FFF}    // R7 largest positive
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(logic [15:0] ph);
    meas_phase = ph;
    ref_switch = 1'b1;
    tick();
    ref_switch = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; meas_phase = 16'h0005; ref_switch = 1'b0; hold_exit = 1'b0;
    hitless_hold = 1'b0; clr_n = 1'b1; slope_lim = 15'h7FFF;
    tick(); tick();
    check("R1 offset in reset", offset_out, 16'h0000);
    rst_n = 1'b1;
    tick();
    check("R1 offset after reset", offset_out, 16'h0000);
    check("R1 err after reset", err_out, 16'h0005);

    foreach (VEC[i]) begin
      slope_lim = 15'h7FFF;
      capture(VEC[i][63:48]);
      meas_phase = VEC[i][47:32];
      slope_lim  = VEC[i][30:16];
      #1;
      check("R7/R8 vector err", err_out, VEC[i][15:0]);
    end
    slope_lim = 15'h7FFF;

    // R2: switch capture with mode low, then with mode high
    hitless_hold = 1'b0;
    capture(16'h1234);
    check("R2 capture mode low", offset_out, 16'h1234);
    check("R2 err zero after switch", err_out, 16'h0000);
    hitless_hold = 1'b1;
    capture(16'h2345);
    check("R2 capture mode high", offset_out, 16'h2345);

    // R4: exit with mode low keeps the offset
    hitless_hold = 1'b0; meas_phase = 16'h3000; hold_exit = 1'b1;
    tick();
    hold_exit = 1'b0;
    check("R4 offset kept", offset_out, 16'h2345);
    check("R4 err toward old phase", err_out, 16'h0CBB);

    // R3: exit with mode high recaptures
    hitless_hold = 1'b1; hold_exit = 1'b1;
    tick();
    hold_exit = 1'b0;
    check("R3 offset recaptured", offset_out, 16'h3000);

    // R5: clear low at one edge only is ignored
    clr_n = 1'b0;
    tick();
    clr_n = 1'b1;
    tick(); tick(); tick();
    check("R5 short clear ignored", offset_out, 16'h3000);

    // R5: clear low over two edges, cleared at third edge after the first
    clr_n = 1'b0;
    tick(); tick();
    tick();
    check("R5 not yet cleared", offset_out, 16'h3000);
    tick();
    check("R5 cleared", offset_out, 16'h0000);

    // R6: clear held low beats both strobes in the same cycle
    meas_phase = 16'h0333; ref_switch = 1'b1; hold_exit = 1'b1; hitless_hold = 1'b1;
    tick(); tick();
    ref_switch = 1'b0; hold_exit = 1'b0;
    check("R6 offset held at zero", offset_out, 16'h0000);
    check("R6 err follows reference", err_out, 16'h0333);

    // release clear; capture works again
    clr_n = 1'b1;
    tick(); tick(); tick();
    capture(16'h0ABC);
    check("R2 capture after clear release", offset_out, 16'h0ABC);

    // R1: reset in mid-run zeroes offset
    rst_n = 1'b0;
    #1;
    check("R1 async reset", offset_out, 16'h0000);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule